// File: doc/BRIEF.md
# Receive Lane Word Lock Controller

This block serves one receive lane. It runs in that lane's parallel (word) clock domain. A downstream bit-slip realigner shifts the word boundary by one bit each time it sees a slip request. The controller registers every incoming word and compares it with a programmed lock pattern. As long as the two differ, it sends slip requests to the realigner, one at a time. After each request it waits for the realigner and its own registers to settle, then compares again.

A search begins with a start pulse. It ends in one of two ways: the lock flag is raised when the pattern is found, or the failure flag is raised when the slip budget runs out with no match. The slip request output is registered, and its shape is fixed. Each request is held high for a fixed number of cycles and is followed by a long low gap. A realigner that sees the signal through a path of unknown skew therefore counts every request exactly once.

Top module: `wordlock_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `slip_req`, `locked`, `busy` and `fail` are all 0.
- R2: The input word passes through one register before it is compared. If the word already equals `pattern`, a start pulse sampled at clock edge e0 sets `busy` after e0. At edge e1, `locked` goes to 1 and `busy` goes to 0. No slip request is issued.
- R3: Every slip request is high on `slip_req` for exactly 2 consecutive cycles.
- R4: Between requests, `slip_req` stays low for at least 3 cycles. Within one search, consecutive rising edges of `slip_req` are exactly 7 cycles apart (2 high cycles, 4 settle cycles, 1 compare cycle).
- R5: Requests continue until the registered word equals `pattern`. The number of requests in a search equals the number of slips the lane needs. While `locked` is 1, `busy` and `slip_req` are 0.
- R6: If the compare after the 20th request (2 × word width) still finds no match, the controller sets `fail`, returns to idle, and holds `busy` and `locked` at 0. It never issues more than 20 requests in one search.
- R7: A match on the compare that follows the 20th request takes priority over the limit. `locked` is set and `fail` stays 0.
- R8: A start pulse while `locked` is 1 clears `locked` in the next cycle, sets `busy`, and begins a new search with a fresh budget of 20 requests.
- R9: A start pulse while `busy` is 1 is ignored. The search carries on, and its request count is unchanged.
- R10: A start pulse while `fail` is 1 clears `fail` in the next cycle and begins a new search.
- R11: The comparison covers every bit of the word. A word that differs from `pattern` only in its most significant bit does not count as a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock of the lane |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a search when not busy |
| pattern | input | WORD_W | Lock pattern, held static during a search |
| rx_word | input | WORD_W | Word delivered by the realigner |
| slip_req | output | 1 | Registered slip request to the realigner |
| locked | output | 1 | Pattern found; word boundary aligned |
| busy | output | 1 | Search in progress |
| fail | output | 1 | Slip budget used up without a match |

## Verification
Two decisions can land on the same compare cycle: the comparison finding the pattern, and the slip budget reaching its limit. The bench provokes this with a realigner model that shows the true pattern only after exactly 20 slips. Until then it presents the pattern with its top bit flipped. The pass criterion is that `locked` rises, `fail` stays low, and exactly 20 requests are counted. The bench also runs the neighbouring cases, one with a pattern that never appears and one with a start pulse arriving in the middle of a search, to show that the limit and the start input each act only in their own state.

// File: rtl/wordlock_pkg.sv
package wordlock_pkg;

  typedef enum logic [2:0] {
    WL_IDLE     = 3'd0,
    WL_COMPARE  = 3'd1,
    WL_SLIP_HI  = 3'd2,
    WL_SLIP_GAP = 3'd3,
    WL_LOCKED   = 3'd4
  } wl_state_e;

endpackage

// File: rtl/wl_sync_reg.sv
module wl_sync_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/wl_word_match.sv
module wl_word_match #(
  parameter int W = 10
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] ref_word,
  output logic         equal
);
  logic [W-1:0] diff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = word[i] ^ ref_word[i];
  end

  assign equal = ~|diff;
endmodule

// File: rtl/wl_interval_timer.sv
module wl_interval_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/wl_slip_tally.sv
module wl_slip_tally #(
  parameter int LIMIT = 20,
  parameter int CW    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (bump)    count <= count + 1'b1;
  end

  assign at_limit = (count == CW'(LIMIT));
endmodule

// File: rtl/wl_fsm.sv
module wl_fsm
  import wordlock_pkg::*;
#(
  parameter int TW           = 3,
  parameter int PULSE_CYCLES = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          match,
  input  logic          tmr_expired,
  input  logic          at_limit,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tally_clear,
  output logic          tally_bump,
  output logic          slip_drive,
  output logic          locked,
  output logic          busy,
  output logic          fail
);
  wl_state_e state, state_n;
  logic      fail_set, fail_clr;

  always_comb begin
    state_n     = state;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    tally_clear = 1'b0;
    tally_bump  = 1'b0;
    fail_set    = 1'b0;
    fail_clr    = 1'b0;
    unique case (state)
      WL_IDLE: begin
        if (start) begin
          state_n     = WL_COMPARE;
          tally_clear = 1'b1;
          fail_clr    = 1'b1;
        end
      end
      WL_COMPARE: begin
        if (match) begin
          state_n = WL_LOCKED;
        end else if (at_limit) begin
          state_n  = WL_IDLE;
          fail_set = 1'b1;
        end else begin
          state_n    = WL_SLIP_HI;
          tmr_load   = 1'b1;
          tmr_val    = TW'(PULSE_CYCLES - 1);
          tally_bump = 1'b1;
        end
      end
      WL_SLIP_HI: begin
        if (tmr_expired) begin
          state_n  = WL_SLIP_GAP;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYCLES - 1);
        end
      end
      WL_SLIP_GAP: begin
        if (tmr_expired) state_n = WL_COMPARE;
      end
      WL_LOCKED: begin
        if (start) begin
          state_n     = WL_COMPARE;
          tally_clear = 1'b1;
        end
      end
      default: state_n = WL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WL_IDLE;
      locked <= 1'b0;
      busy   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      state  <= state_n;
      locked <= (state_n == WL_LOCKED);
      busy   <= (state_n == WL_COMPARE) || (state_n == WL_SLIP_HI) ||
                (state_n == WL_SLIP_GAP);
      if (fail_set)      fail <= 1'b1;
      else if (fail_clr) fail <= 1'b0;
    end
  end

  assign slip_drive = (state == WL_SLIP_HI);
endmodule

// File: rtl/wordlock_ctrl.sv
module wordlock_ctrl #(
  parameter int WORD_W        = 10,
  parameter int PULSE_CYCLES  = 2,
  parameter int SETTLE_CYCLES = 4,
  parameter int MAX_SLIPS     = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] pattern,
  input  logic [WORD_W-1:0] rx_word,
  output logic              slip_req,
  output logic              locked,
  output logic              busy,
  output logic              fail
);
  localparam int LONGEST = (PULSE_CYCLES > SETTLE_CYCLES) ? PULSE_CYCLES : SETTLE_CYCLES;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int CW      = $clog2(MAX_SLIPS + 1);

  logic [WORD_W-1:0] word_q;
  logic              match, tmr_expired, at_limit;
  logic              tmr_load, tally_clear, tally_bump, slip_drive;
  logic [TW-1:0]     tmr_val;

  wl_sync_reg #(.W(WORD_W)) u_in_reg (
    .clk(clk), .rst(rst), .d(rx_word), .q(word_q)
  );

  wl_word_match #(.W(WORD_W)) u_match (
    .word(word_q), .ref_word(pattern), .equal(match)
  );

  wl_interval_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  wl_slip_tally #(.LIMIT(MAX_SLIPS), .CW(CW)) u_tally (
    .clk(clk), .rst(rst), .clear(tally_clear), .bump(tally_bump),
    .at_limit(at_limit)
  );

  wl_fsm #(
    .TW(TW), .PULSE_CYCLES(PULSE_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .match(match),
    .tmr_expired(tmr_expired), .at_limit(at_limit),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tally_clear(tally_clear), .tally_bump(tally_bump),
    .slip_drive(slip_drive), .locked(locked), .busy(busy), .fail(fail)
  );

  wl_sync_reg #(.W(1)) u_out_reg (
    .clk(clk), .rst(rst), .d(slip_drive), .q(slip_req)
  );
endmodule

// File: rtl/wordlock_ctrl_chk.sv
module wordlock_ctrl_chk #(
  parameter int PULSE_CYCLES = 2,
  parameter int LOW_MIN      = 3,
  parameter int MAX_SLIPS    = 20
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic slip_req,
  input logic locked,
  input logic busy,
  input logic fail
);
  logic [7:0] hi_run, low_run, tally;
  logic       seen_pulse, slip_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run     <= '0;
      low_run    <= '0;
      tally      <= '0;
      seen_pulse <= 1'b0;
      slip_prev  <= 1'b0;
    end else begin
      slip_prev <= slip_req;
      hi_run    <= slip_req ? hi_run + 1'b1 : 8'd0;
      low_run   <= slip_req ? 8'd0 : ((low_run == 8'hFF) ? low_run : low_run + 1'b1);
      if (slip_req) seen_pulse <= 1'b1;
      if (start && !busy)             tally <= '0;
      else if (slip_req && !slip_prev) tally <= tally + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!slip_req && !locked && !busy && !fail));

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!slip_req && slip_prev) |-> (hi_run == PULSE_CYCLES));

  p_pulse_cap_r3: assert property (@(posedge clk) disable iff (rst)
    slip_req |-> (hi_run < PULSE_CYCLES));

  p_low_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (slip_req && !slip_prev && seen_pulse) |-> (low_run >= LOW_MIN));

  p_lock_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    locked |-> (!busy && !slip_req));

  p_budget_r6: assert property (@(posedge clk) disable iff (rst)
    tally <= MAX_SLIPS);

  p_fail_idle_r6: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!busy && !locked));

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (locked && start) |=> (busy && !locked));

  p_fail_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (fail && start) |=> (busy && !fail));
endmodule

bind wordlock_ctrl wordlock_ctrl_chk #(
  .PULSE_CYCLES(PULSE_CYCLES), .LOW_MIN(3), .MAX_SLIPS(MAX_SLIPS)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .slip_req(slip_req),
  .locked(locked), .busy(busy), .fail(fail)
);

// File: tb/wordlock_ctrl_bench.sv
module wordlock_ctrl_bench;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] pattern = 10'h07C;
  logic [W-1:0] rx_word;
  logic         slip_req, locked, busy, fail;

  int checks = 0, errors = 0;
  int slips = 0, base = 0, tgt = 0, mode = 1;
  int cyc = 0, last_rise = -1, hi_run = 0, bad_hi = 0, bad_gap = 0;
  bit prev = 1'b0;

  always #2 clk = ~clk;

  wordlock_ctrl u_wordlock_ctrl (
    .clk(clk), .rst(rst), .start(start), .pattern(pattern), .rx_word(rx_word),
    .slip_req(slip_req), .locked(locked), .busy(busy), .fail(fail)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int n);
    logic [2*W-1:0] t;
    t = {v, v} << n;
    return t[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] lane_word(input int m, input int target, input int rel);
    if (m == 0) return rotl(pattern, (((target - rel) % W) + W) % W);
    return (rel == target) ? pattern : (pattern ^ (W'(1) << (W - 1)));
  endfunction

  assign rx_word = lane_word(mode, tgt, slips - base);

  // realigner model and pulse-shape monitor
  always @(negedge clk) begin
    cyc++;
    if (slip_req && !prev) begin
      slips++;
      if (last_rise >= 0 && (cyc - last_rise) != 7) bad_gap++;
      last_rise = cyc;
    end
    if (!slip_req && prev && hi_run != 2) bad_hi++;
    hi_run = slip_req ? hi_run + 1 : 0;
    prev   = slip_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic begin_search(input int m, input int target);
    mode = m; tgt = target; base = slips; last_rise = -1;
    pulse_start();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!slip_req && !locked && !busy && !fail, "R1 outputs in reset",
        {slip_req, locked, busy, fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!slip_req && !locked && !busy && !fail, "R1 outputs after reset",
        {slip_req, locked, busy, fail}, 0);
  endtask

  task automatic t_immediate();
    begin_search(1, 0);
    chk(busy && !locked, "R2 busy one cycle after start", {busy, locked}, 2);
    @(negedge clk);
    chk(locked && !busy, "R2 locked two cycles after start", {locked, busy}, 2);
    chk(slips == base, "R2 no slip when already aligned", slips - base, 0);
  endtask

  task automatic t_rotate();
    begin_search(0, 3);
    @(negedge clk);
    wait_done();
    chk(locked && !fail, "R5 locked after rotation search", {locked, fail}, 2);
    chk(slips - base == 3, "R5 request count for rotation", slips - base, 3);
  endtask

  task automatic t_msb_only();
    begin_search(1, 5);
    @(negedge clk);
    wait_done();
    chk(slips - base == 5, "R11 msb-only difference is a mismatch", slips - base, 5);
    chk(locked, "R11 locked once full word equal", locked, 1);
  endtask

  task automatic t_limit_fail();
    begin_search(1, 99);
    @(negedge clk);
    wait_done();
    chk(slips - base == 20, "R6 requests before giving up", slips - base, 20);
    chk(fail && !busy && !locked, "R6 fail flag and idle", {fail, busy, locked}, 4);
    repeat (10) @(negedge clk);
    chk(slips - base == 20 && !slip_req, "R6 no request after failure", slips - base, 20);
  endtask

  task automatic t_fail_clear();
    begin_search(1, 0);
    chk(!fail && busy, "R10 start clears fail", {fail, busy}, 1);
    @(negedge clk);
    chk(locked, "R10 new search locks", locked, 1);
  endtask

  task automatic t_edge_limit();
    begin_search(1, 20);
    @(negedge clk);
    wait_done();
    chk(slips - base == 20, "R7 request count at limit", slips - base, 20);
    chk(locked && !fail, "R7 match wins over limit", {locked, fail}, 2);
  endtask

  task automatic t_restart();
    begin_search(1, 2);
    chk(!locked && busy, "R8 start in locked clears lock", {locked, busy}, 1);
    wait_done();
    chk(slips - base == 2 && locked, "R8 restarted search relocks", slips - base, 2);
  endtask

  task automatic t_busy_start();
    begin_search(1, 4);
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();
    wait_done();
    chk(slips - base == 4 && locked, "R9 start while busy ignored", slips - base, 4);
  endtask

  initial begin
    t_reset();
    t_immediate();
    t_rotate();
    t_msb_only();
    t_limit_fail();
    t_fail_clear();
    t_edge_limit();
    t_restart();
    t_busy_start();
    chk(bad_hi == 0, "R3 every request two cycles high", bad_hi, 0);
    chk(bad_gap == 0, "R4 request spacing seven cycles", bad_gap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule